// File: doc/BRIEF.md
# Memory Command Energy Accumulator

This block sits beside a DRAM controller's command issue stage and keeps a running estimate of the energy spent by the commands it sees. Each clock at most one command is presented with a type code; the block looks up a programmable 8-bit cost for that type and adds it to a saturating running total. Opening a page is charged once, at the activate. That cost is programmed to cover both the activate and the precharge that will later close the page. Precharges therefore add nothing, and refreshes are left out because they run at a fixed rate.

A window timer of programmable length divides time into intervals. At the last cycle of each interval the running total is copied into a sample register for a power manager to read, a one-cycle done pulse is raised, and the total restarts for the next interval. The three costs are loaded through a single 32-bit write port holding a packed image. The same image can be read back at any time, and the costs may be rewritten while traffic is flowing.

Top module: `cmd_energy_acc`

## Requirements
- R1: While `rst` is high at a clock edge, the total, the sample, the done pulse and the weight image are cleared to zero on that edge.
- R2: After reset all three weights are zero, so commands add nothing until weights are written.
- R3: The packed weight image places the activate cost in bits 7:0, the read cost in bits 15:8 and the write cost in bits 23:16. Bits 31:24 are ignored on write and read back as zero.
- R4: A valid command with code 1 (activate) adds the activate cost. Code 3 (read) adds the read cost. Code 4 (write) adds the write cost.
- R5: A valid command with code 2 (precharge), code 5 (refresh), code 0 (idle) or any other code adds nothing. A command with `cmd_valid` low adds nothing, whatever its code.
- R6: The running total appears on `energy_total` one cycle after the command's clock edge.
- R7: A weight write in one cycle applies to commands from the next cycle onward. A command in the same cycle as the write uses the old cost.
- R8: The running total saturates at 2^SUM_W-1 and never wraps.
- R9: When `win_len` is L (L≥1), every L-th clock edge ends a window. On that edge `win_sample` takes the running total and `win_done` rises for one cycle. The total restarts from the cost of the command in that same cycle, which belongs to the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the weight image |
| cfg_wdata | input | 32 | Packed weight image to write |
| cfg_rdata | output | 32 | Current packed weight image |
| win_len | input | WIN_W | Window length in cycles |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_code | input | 3 | Command type code |
| energy_total | output | SUM_W | Running energy total of the current window |
| win_sample | output | SUM_W | Total captured at the end of the last window |
| win_done | output | 1 | One-cycle pulse when a window closes |

## Verification
The bench checks that precharge and refresh are free. A design that charged them separately would double-count page opens. It writes a weight in the same cycle as a read, so a design that forwarded the new cost early would be off by the difference. It pushes the total far past its ceiling, where a wrapping adder would drop to a small value. It also places a command on the exact closing cycle of a window: a design that credited it to the old window would show a larger sample and a smaller restarted total.

// File: rtl/cea_pkg.sv
package cea_pkg;
  localparam int WGT_W = 8;

  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_PRE   = 3'd2,
    CMD_RD    = 3'd3,
    CMD_WR    = 3'd4,
    CMD_REF   = 3'd5
  } cmd_e;

  typedef struct packed {
    logic [WGT_W-1:0] wr;
    logic [WGT_W-1:0] rd;
    logic [WGT_W-1:0] act;
  } weights_t;
endpackage

// File: rtl/cea_weight_regs.sv
module cea_weight_regs
  import cea_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  output weights_t    wgt,
  output logic [31:0] rdata
);
  weights_t wgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wgt_q <= '0;
    end else if (we) begin
      wgt_q.act <= wdata[7:0];
      wgt_q.rd  <= wdata[15:8];
      wgt_q.wr  <= wdata[23:16];
    end
  end

  assign wgt   = wgt_q;
  assign rdata = {8'h00, wgt_q.wr, wgt_q.rd, wgt_q.act};

  // R7: weights only move on a write strobe
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(wgt_q));
  // R3: write lands in the documented field positions
  p_field_r3: assert property (@(posedge clk) disable iff (rst)
    we |=> rdata == {8'h00, $past(wdata[23:0])});
endmodule

// File: rtl/cea_window_timer.sv
module cea_window_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end
);
  logic [WIN_W-1:0] cnt_q;

  assign win_end = (win_len <= 1) || (cnt_q >= win_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (win_end) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R9: a window close always restarts the count
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    win_end |=> cnt_q == '0);
endmodule

// File: rtl/cea_accum.sv
module cea_accum #(
  parameter int SUM_W = 16,
  parameter int ADD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADD_W-1:0] cost,
  input  logic             win_end,
  output logic [SUM_W-1:0] total,
  output logic [SUM_W-1:0] sample,
  output logic             done
);
  localparam logic [SUM_W-1:0] MAX_V = {SUM_W{1'b1}};

  logic [SUM_W-1:0] sum_q, smp_q;
  logic             done_q;
  logic [SUM_W:0]   wide;

  assign wide = {1'b0, sum_q} + (SUM_W+1)'(cost);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      smp_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= win_end;
      if (win_end) begin
        smp_q <= sum_q;
        sum_q <= SUM_W'(cost);
      end else begin
        sum_q <= wide[SUM_W] ? MAX_V : wide[SUM_W-1:0];
      end
    end
  end

  assign total  = sum_q;
  assign sample = smp_q;
  assign done   = done_q;

  // R8: inside a window the total never goes down
  p_monotonic_r8: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> sum_q >= $past(sum_q));
  // R8: once saturated the total stays pinned
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (sum_q == MAX_V && !win_end) |=> sum_q == MAX_V);
  // R9: sample captures the closing total
  p_sample_r9: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (smp_q == $past(sum_q)) && done_q);
endmodule

// File: rtl/cmd_energy_acc.sv
module cmd_energy_acc
  import cea_pkg::*;
#(
  parameter int SUM_W = 16,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [WIN_W-1:0] win_len,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  output logic [SUM_W-1:0] energy_total,
  output logic [SUM_W-1:0] win_sample,
  output logic             win_done
);
  weights_t         wgt;
  logic [WGT_W-1:0] cost;
  logic             win_end;

  cea_weight_regs u_wgt (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .wgt(wgt), .rdata(cfg_rdata)
  );

  cea_window_timer #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .win_len(win_len), .win_end(win_end)
  );

  always_comb begin
    cost = '0;
    if (cmd_valid) begin
      case (cmd_code)
        CMD_ACT: cost = wgt.act;
        CMD_RD:  cost = wgt.rd;
        CMD_WR:  cost = wgt.wr;
        default: cost = '0;
      endcase
    end
  end

  cea_accum #(.SUM_W(SUM_W), .ADD_W(WGT_W)) u_acc (
    .clk(clk), .rst(rst), .cost(cost), .win_end(win_end),
    .total(energy_total), .sample(win_sample), .done(win_done)
  );

  // R5: a precharge or refresh leaves the total unchanged
  p_free_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_code == CMD_PRE || cmd_code == CMD_REF) && !win_end)
      |=> energy_total == $past(energy_total));
  // R2: after reset weights are zero, so a first command adds nothing
  p_zero_after_reset_r2: assert property (@(posedge clk)
    ($past(rst) && !rst && !win_end) |=> energy_total == '0);
endmodule

// File: tb/tb_cmd_energy_acc.sv
`timescale 1ns/1ps
module tb_cmd_energy_acc;
  localparam int SUM_W = 16;
  localparam int WIN_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [31:0]      cfg_wdata = '0;
  logic [31:0]      cfg_rdata;
  logic [WIN_W-1:0] win_len = '1;
  logic             cmd_valid = 1'b0;
  logic [2:0]       cmd_code = '0;
  logic [SUM_W-1:0] energy_total, win_sample;
  logic             win_done;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  cmd_energy_acc #(.SUM_W(SUM_W), .WIN_W(WIN_W)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .win_len(win_len), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .energy_total(energy_total),
    .win_sample(win_sample), .win_done(win_done)
  );

  task automatic check(input string req, input longint got, input longint exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [WIN_W-1:0] len);
    @(negedge clk);
    rst = 1'b1; cmd_valid = 1'b0; cfg_we = 1'b0; win_len = len;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic wr_cfg(input logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic v, input logic [2:0] c);
    cmd_valid = v; cmd_code = c;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset('1);
    check("R1 total",  energy_total, 0);
    check("R1 sample", win_sample, 0);
    check("R1 done",   win_done, 0);
    check("R1 rdata",  cfg_rdata, 0);
    issue(1'b1, 3'd1);
    check("R2 act with zero weights", energy_total, 0);
    issue(1'b1, 3'd4);
    check("R2 wr with zero weights", energy_total, 0);
  endtask

  task automatic t_image();
    do_reset('1);
    wr_cfg(32'hFFAABBCC);
    check("R3 readback", cfg_rdata, 32'h00AABBCC);
    issue(1'b1, 3'd1);
    check("R3 act field", energy_total, 8'hCC);
  endtask

  task automatic t_costs();
    do_reset('1);
    wr_cfg(32'h0007_0305);
    issue(1'b1, 3'd1); check("R4 act",  energy_total, 5);
    issue(1'b1, 3'd3); check("R4 rd",   energy_total, 8);
    issue(1'b1, 3'd4); check("R4 wr",   energy_total, 15);
    issue(1'b1, 3'd2); check("R5 pre",  energy_total, 15);
    issue(1'b1, 3'd5); check("R5 ref",  energy_total, 15);
    issue(1'b1, 3'd7); check("R5 other", energy_total, 15);
    issue(1'b0, 3'd1); check("R5 invalid act", energy_total, 15);
    issue(1'b1, 3'd0); check("R5 idle", energy_total, 15);
  endtask

  task automatic t_latency();
    do_reset('1);
    wr_cfg(32'h0000_0009);
    cmd_valid = 1'b1; cmd_code = 3'd1;
    @(posedge clk); #1;
    check("R6 visible after edge", energy_total, 9);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_live_write();
    do_reset('1);
    wr_cfg(32'h0000_0300);
    cfg_we = 1'b1; cfg_wdata = 32'h0000_0900;
    cmd_valid = 1'b1; cmd_code = 3'd3;
    step();
    cfg_we = 1'b0;
    check("R7 same-cycle uses old", energy_total, 3);
    step();
    cmd_valid = 1'b0;
    check("R7 next cycle uses new", energy_total, 12);
  endtask

  task automatic t_saturate();
    do_reset('1);
    wr_cfg(32'h0000_00FF);
    cmd_valid = 1'b1; cmd_code = 3'd1;
    for (int i = 0; i < 300; i++) step();
    cmd_valid = 1'b0;
    check("R8 saturated", energy_total, 65535);
    issue(1'b1, 3'd1);
    check("R8 no wrap", energy_total, 65535);
  endtask

  task automatic t_window();
    do_reset(16'd4);
    wr_cfg(32'h0000_000A);           // edge 1
    cmd_valid = 1'b1; cmd_code = 3'd1;
    step(); step();                  // edges 2,3
    check("R9 before close", energy_total, 20);
    check("R9 done low", win_done, 0);
    step();                          // edge 4 closes
    check("R9 done pulse", win_done, 1);
    check("R9 sample", win_sample, 20);
    check("R9 close-cycle cmd in new window", energy_total, 10);
    step();                          // edge 5
    check("R9 pulse one cycle", win_done, 0);
    step(); step(); step();          // edges 6,7,8
    check("R9 second done", win_done, 1);
    check("R9 second sample", win_sample, 40);
    check("R9 second restart", energy_total, 10);
    cmd_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    t_image();
    t_costs();
    t_latency();
    t_live_write();
    t_saturate();
    t_window();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule